// File: doc/BRIEF.md
# Cipher Key and IV Context Loader

This block executes the three context commands that a command sequencer hands to it: key load, IV load and IV store. It holds two key contexts, each with a byte length and up to 32 key bytes, four 128-bit IV contexts, and the current block mode (ECB or CBC) and direction (encrypt or decrypt). A cipher datapath reads any key or IV context through plain read-select pins.

The sequencer presents one command at a time on a valid/ready channel. Each command carries:
- the opcode,
- the 32-bit command word,
- the number of payload words present in the sequencer's buffer,
- the payload words themselves.

A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while an IV store is waiting for its memory write to be taken. The loader answers every command it takes with a single-cycle `done` pulse and an `ok` flag. The sequencer clears its buffer on `ok`. On a failure it keeps the buffer, for example to retry once more payload has arrived.

An IV store raises a memory write request on a second valid/ready channel. The address and data stay constant until `wr_ready` is seen high. The memory master that performs the write sits outside this block.

Top module: `kctx_loader`

## Requirements
- R1: After reset:
  - every key length, key byte and IV bit reads zero;
  - `cbc_o` and `encrypt_o` are 0;
  - `done` and `wr_valid` are low;
  - `cmd_ready` is high.
- R2: In a key command (`cmd_op`=0), bits 17:16 give the mode and bit 20 the direction.
  - Mode 0 is ECB (`cbc_o`=0) and mode 1 is CBC (`cbc_o`=1). Bit 20 set means encrypt (`encrypt_o`=1).
  - Mode 2 or 3 answers `ok`=0 and changes no context, mode or direction.
- R3: A key command whose built-in select (bits 26:24) is nonzero replaces the context named by bit 27, and succeeds whatever the payload count.
  - The context's length becomes 32.
  - Key byte 0 becomes the select value and every other byte becomes zero.
- R4: A key command with select 0 takes its length from code bits 23:22: code 0 is 16 bytes, 1 is 24 bytes and 2 is 32 bytes.
  - Payload word j is copied into key bytes 4j..4j+3, least significant byte first, for j below length/4.
  - The length is updated. Key bytes beyond the new length keep their old values.
- R5: Length code 3 (64 bytes) answers `ok`=0 and leaves the key context unchanged. A valid mode field still updates mode and direction.
- R6: A host key with fewer payload words than length/4 answers `ok`=0 and leaves the key context unchanged. A valid mode field still updates mode and direction.
- R7: An IV command (`cmd_op`=1) with at least 4 payload words writes word j into IV bits 32j+31..32j of the context named by bits 27:26. With fewer words it answers `ok`=0 and changes nothing.
- R8: An IV store (`cmd_op`=2) with at least one payload word behaves as follows:
  - From the next cycle it raises `wr_valid`, with `wr_addr` = {command bits 7:0, payload word 0} and `wr_data` = the IV of the context named by bits 27:26.
  - It holds both stable, with `cmd_ready` low, until `wr_ready`.
  - `done` with `ok`=1 follows in the cycle after the handshake.
- R9: An IV store with no payload word answers `ok`=0 and raises no write request.
- R10: Reserved opcode 3 answers `ok`=0 and changes no state.
- R11: Every command other than a successful IV store is answered with `done` high in the cycle right after it is taken. `done` lasts one cycle per command and is never raised without a command or write handshake behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Loader can take a command |
| cmd_op | input | 2 | 0 key, 1 IV, 2 IV store, 3 reserved |
| cmd_word | input | 32 | Command word |
| pld_cnt | input | CNT_W (4) | Payload words present |
| pld_words | input | PLD_MAX*32 (256) | Payload words, word 0 in the low bits |
| done | output | 1 | Single-cycle command answer |
| ok | output | 1 | Command succeeded, valid with done |
| wr_valid | output | 1 | Memory write request pending |
| wr_ready | input | 1 | Memory master takes the request |
| wr_addr | output | 40 | Write byte address |
| wr_data | output | 128 | IV to write |
| key_rd_ctx | input | 1 | Key context to read |
| key_len_o | output | LEN_W (6) | Length in bytes of the read key context |
| key_o | output | KEY_BYTES*8 (256) | Key bytes, byte 0 in the low bits |
| iv_rd_ctx | input | 2 | IV context to read |
| iv_o | output | 128 | IV of the read context |
| cbc_o | output | 1 | Current mode is CBC |
| encrypt_o | output | 1 | Current direction is encrypt |

## Verification
Wrong internal state in this block shows up in three ways:
- A mis-decoded field or a bad write enable appears on `key_o`, `key_len_o` or `iv_o` as soon as the affected context is selected, in the cycle after the command's answer.
- A wrong success test shows as a wrong `ok` in the very next cycle.
- A wrong address, a wrong IV snapshot or a write request that drops early appears on the write channel while it waits.

The bench stalls `wr_ready` to expose the last of these.

// File: rtl/kctx_pkg.sv
package kctx_pkg;
  localparam int WORD_W     = 32;
  localparam int KEY_CTX_N  = 2;
  localparam int IV_CTX_N   = 4;
  localparam int IV_W       = 128;
  localparam int IV_WORDS   = IV_W / WORD_W;
  localparam int ADDR_W     = 40;
  localparam int BUILTIN_LEN = 32;

  // command word field positions
  localparam int F_KCTX     = 27;
  localparam int F_SEL_LO   = 24;
  localparam int F_LEN_LO   = 22;
  localparam int F_ENC      = 20;
  localparam int F_MODE_LO  = 16;
  localparam int F_IVCTX_LO = 26;

  typedef enum logic [1:0] {
    OP_KEY      = 2'd0,
    OP_IV       = 2'd1,
    OP_STORE_IV = 2'd2,
    OP_RSVD     = 2'd3
  } kctx_op_e;

  typedef enum logic {
    MODE_ECB = 1'b0,
    MODE_CBC = 1'b1
  } kctx_mode_e;

  typedef struct packed {
    logic       key_ctx;
    logic [2:0] sel;
    logic [1:0] len_code;
    logic       enc;
    logic [1:0] mode;
    logic [1:0] iv_ctx;
    logic [7:0] addr_hi;
  } kctx_fields_t;

  function automatic logic [6:0] len_from_code(input logic [1:0] code);
    logic [6:0] r;
    if (code == 2'd3) r = 7'd64;
    else              r = 7'd16 + {2'b00, code, 3'b000};
    return r;
  endfunction
endpackage

// File: rtl/kctx_decode.sv
module kctx_decode
  import kctx_pkg::*;
#(
  parameter int KEY_BYTES = 32,
  parameter int PLD_MAX   = 8,
  localparam int CNT_W    = $clog2(PLD_MAX + 1),
  localparam int LEN_W    = $clog2(KEY_BYTES + 1),
  localparam int NW       = KEY_BYTES / 4
) (
  input  logic [WORD_W-1:0]         word,
  input  logic [CNT_W-1:0]          pld_cnt,
  input  logic [PLD_MAX*WORD_W-1:0] pld_words,
  output kctx_fields_t              f,
  output logic                      mode_ok,
  output logic                      key_ok,
  output logic                      iv_ok,
  output logic                      st_ok,
  output logic [LEN_W-1:0]          key_wlen,
  output logic [NW-1:0]             key_wmask,
  output logic [KEY_BYTES*8-1:0]    key_wdata
);
  logic       builtin;
  logic [6:0] hlen;
  logic [4:0] hwords;
  logic       host_ok;
  logic       unused_bits;

  assign f.key_ctx  = word[F_KCTX];
  assign f.sel      = word[F_SEL_LO +: 3];
  assign f.len_code = word[F_LEN_LO +: 2];
  assign f.enc      = word[F_ENC];
  assign f.mode     = word[F_MODE_LO +: 2];
  assign f.iv_ctx   = word[F_IVCTX_LO +: 2];
  assign f.addr_hi  = word[7:0];
  assign unused_bits = ^{word[31:28], word[21], word[19:18], word[15:8]};

  assign builtin = (f.sel != 3'd0);
  assign hlen    = len_from_code(f.len_code);
  assign hwords  = hlen[6:2];
  assign host_ok = (8'(hlen) <= 8'(KEY_BYTES)) && (8'(pld_cnt) >= 8'(hwords));

  assign mode_ok = (f.mode[1] == 1'b0);
  assign key_ok  = mode_ok && (builtin || host_ok);
  assign iv_ok   = 8'(pld_cnt) >= 8'(IV_WORDS);
  assign st_ok   = (pld_cnt != '0) && (8'(f.iv_ctx) < 8'(IV_CTX_N));

  assign key_wlen  = builtin ? LEN_W'(BUILTIN_LEN) : LEN_W'(hlen);
  assign key_wdata = builtin ? {{(KEY_BYTES*8-3){1'b0}}, f.sel}
                             : pld_words[KEY_BYTES*8-1:0];

  for (genvar w = 0; w < NW; w++) begin : g_mask
    assign key_wmask[w] = builtin || (8'(w) < 8'(hwords));
  end
endmodule

// File: rtl/kctx_key_bank.sv
module kctx_key_bank #(
  parameter int NCTX   = 2,
  parameter int NBYTES = 32,
  localparam int CW    = $clog2(NCTX),
  localparam int LEN_W = $clog2(NBYTES + 1),
  localparam int NW    = NBYTES / 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CW-1:0]     wctx,
  input  logic [LEN_W-1:0]  wlen,
  input  logic [NW-1:0]     wmask,
  input  logic [NBYTES*8-1:0] wdata,
  input  logic [CW-1:0]     rctx,
  output logic [LEN_W-1:0]  rlen,
  output logic [NBYTES*8-1:0] rkey
);
  logic [31:0]      key_q [NCTX][NW];
  logic [LEN_W-1:0] len_q [NCTX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCTX; c++) begin
        len_q[c] <= '0;
        for (int w = 0; w < NW; w++) key_q[c][w] <= '0;
      end
    end else if (we) begin
      for (int c = 0; c < NCTX; c++) begin
        if (wctx == CW'(c)) begin
          len_q[c] <= wlen;
          for (int w = 0; w < NW; w++)
            if (wmask[w]) key_q[c][w] <= wdata[32*w +: 32];
        end
      end
    end
  end

  assign rlen = len_q[rctx];
  for (genvar w = 0; w < NW; w++) begin : g_rd
    assign rkey[32*w +: 32] = key_q[rctx][w];
  end
endmodule

// File: rtl/kctx_iv_bank.sv
module kctx_iv_bank #(
  parameter int NCTX = 4,
  parameter int W    = 128,
  localparam int CW  = $clog2(NCTX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wctx,
  input  logic [W-1:0]  wdata,
  input  logic [CW-1:0] rctx_a,
  output logic [W-1:0]  rdata_a,
  input  logic [CW-1:0] rctx_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] iv_q [NCTX];

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        iv_q[c] <= '0;
      else if (we && wctx == CW'(c))     iv_q[c] <= wdata;
    end
  end

  assign rdata_a = iv_q[rctx_a];
  assign rdata_b = iv_q[rctx_b];
endmodule

// File: rtl/kctx_loader.sv
module kctx_loader
  import kctx_pkg::*;
#(
  parameter int KEY_BYTES = 32,
  parameter int PLD_MAX   = 8,
  localparam int CNT_W    = $clog2(PLD_MAX + 1),
  localparam int LEN_W    = $clog2(KEY_BYTES + 1),
  localparam int KCW      = $clog2(KEY_CTX_N),
  localparam int ICW      = $clog2(IV_CTX_N),
  localparam int NW       = KEY_BYTES / 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [1:0]                cmd_op,
  input  logic [WORD_W-1:0]         cmd_word,
  input  logic [CNT_W-1:0]          pld_cnt,
  input  logic [PLD_MAX*WORD_W-1:0] pld_words,
  output logic                      done,
  output logic                      ok,
  output logic                      wr_valid,
  input  logic                      wr_ready,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [IV_W-1:0]           wr_data,
  input  logic [KCW-1:0]            key_rd_ctx,
  output logic [LEN_W-1:0]          key_len_o,
  output logic [KEY_BYTES*8-1:0]    key_o,
  input  logic [ICW-1:0]            iv_rd_ctx,
  output logic [IV_W-1:0]           iv_o,
  output logic                      cbc_o,
  output logic                      encrypt_o
);
  typedef enum logic {ST_IDLE, ST_WRITE} st_e;

  st_e          st_q;
  kctx_op_e     op;
  kctx_fields_t f;
  kctx_mode_e   mode_q;
  logic         enc_q;
  logic         accept, mode_ok, key_ok, iv_ok, st_ok;
  logic         key_we, mode_we, iv_we, st_go, resp_ok;
  logic [LEN_W-1:0]       key_wlen;
  logic [NW-1:0]          key_wmask;
  logic [KEY_BYTES*8-1:0] key_wdata;
  logic [IV_W-1:0]        iv_snap;

  assign op        = kctx_op_e'(cmd_op);
  assign cmd_ready = (st_q == ST_IDLE);
  assign wr_valid  = (st_q == ST_WRITE);
  assign accept    = cmd_valid && cmd_ready;

  kctx_decode #(.KEY_BYTES(KEY_BYTES), .PLD_MAX(PLD_MAX)) u_dec (
    .word(cmd_word), .pld_cnt(pld_cnt), .pld_words(pld_words),
    .f(f), .mode_ok(mode_ok), .key_ok(key_ok), .iv_ok(iv_ok), .st_ok(st_ok),
    .key_wlen(key_wlen), .key_wmask(key_wmask), .key_wdata(key_wdata)
  );

  assign key_we  = accept && (op == OP_KEY) && key_ok;
  assign mode_we = accept && (op == OP_KEY) && mode_ok;
  assign iv_we   = accept && (op == OP_IV) && iv_ok;
  assign st_go   = accept && (op == OP_STORE_IV) && st_ok;

  always_comb begin
    case (op)
      OP_KEY:  resp_ok = key_ok;
      OP_IV:   resp_ok = iv_ok;
      default: resp_ok = 1'b0;
    endcase
  end

  kctx_key_bank #(.NCTX(KEY_CTX_N), .NBYTES(KEY_BYTES)) u_keys (
    .clk(clk), .rst_n(rst_n), .we(key_we), .wctx(KCW'(f.key_ctx)),
    .wlen(key_wlen), .wmask(key_wmask), .wdata(key_wdata),
    .rctx(key_rd_ctx), .rlen(key_len_o), .rkey(key_o)
  );

  kctx_iv_bank #(.NCTX(IV_CTX_N), .W(IV_W)) u_ivs (
    .clk(clk), .rst_n(rst_n), .we(iv_we), .wctx(ICW'(f.iv_ctx)),
    .wdata(pld_words[IV_W-1:0]),
    .rctx_a(iv_rd_ctx), .rdata_a(iv_o),
    .rctx_b(ICW'(f.iv_ctx)), .rdata_b(iv_snap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      done    <= 1'b0;
      ok      <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      mode_q  <= MODE_ECB;
      enc_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      ok   <= 1'b0;
      if (mode_we) begin
        mode_q <= kctx_mode_e'(f.mode[0]);
        enc_q  <= f.enc;
      end
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (st_go) begin
              st_q    <= ST_WRITE;
              wr_addr <= {f.addr_hi, pld_words[31:0]};
              wr_data <= iv_snap;
            end else begin
              done <= 1'b1;
              ok   <= resp_ok;
            end
          end
        end
        ST_WRITE: begin
          if (wr_ready) begin
            st_q <= ST_IDLE;
            done <= 1'b1;
            ok   <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cbc_o     = (mode_q == MODE_CBC);
  assign encrypt_o = enc_q;
endmodule

// File: rtl/kctx_loader_chk.sv
module kctx_loader_chk
  import kctx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [1:0]         cmd_op,
  input logic [WORD_W-1:0]  cmd_word,
  input logic [CNT_W-1:0]   pld_cnt,
  input logic               done,
  input logic               ok,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [IV_W-1:0]    wr_data
);
  localparam logic [CNT_W-1:0] IVW_C = CNT_W'(IV_WORDS);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_BAD_MODE_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_KEY && cmd_word[F_MODE_LO+1]) |=> (done && !ok)); // R2
  AST_SHORT_IV_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_IV && pld_cnt < IVW_C) |=> (done && !ok)); // R7
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R8
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !cmd_ready); // R8
  AST_WR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (done && ok && !wr_valid)); // R8
  AST_NO_PLD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_STORE_IV && pld_cnt == '0) |=> (done && !ok && !wr_valid)); // R9
  AST_RSVD_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_RSVD) |=> (done && !ok)); // R10
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op != OP_STORE_IV) |=> done); // R11
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(acc) || $past(wr_valid && wr_ready))); // R11
endmodule

bind kctx_loader kctx_loader_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_kctx_loader.sv
module tb_kctx_loader;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;
  localparam int LEN_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [31:0] cmd_word = '0;
  logic [CNT_W-1:0] pld_cnt = '0;
  logic [255:0] pld_words = '0;
  logic done, ok, wr_valid, wr_ready = 1'b0;
  logic [39:0] wr_addr;
  logic [127:0] wr_data;
  logic [0:0] key_rd_ctx = '0;
  logic [LEN_W-1:0] key_len_o;
  logic [255:0] key_o;
  logic [1:0] iv_rd_ctx = '0;
  logic [127:0] iv_o;
  logic cbc_o, encrypt_o;

  kctx_loader dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [255:0] m_key [2];
  int           m_len [2];
  logic [127:0] m_iv  [4];
  logic m_cbc = 1'b0, m_enc = 1'b0;
  bit    exp_ok_q [$];
  string exp_req_q [$];
  logic [167:0] exp_wr_q [$];
  int stall_left = 0;

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_key(input bit c, input int sel, input int lc,
                                         input bit enc, input int mode);
    return {4'h1, c, 3'(sel), 2'(lc), 1'b0, enc, 2'b00, 2'(mode), 16'h0};
  endfunction
  function automatic logic [31:0] mk_iv(input int c);
    return {4'h2, 2'(c), 26'h0};
  endfunction
  function automatic logic [31:0] mk_st(input int c, input logic [7:0] hi);
    return {4'h6, 2'(c), 18'h0, hi};
  endfunction

  // monitor: answers and write channel
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_ok_q.size() == 0) chk("R11", "unexpected done", 1, 0);
        else begin
          string r;
          bit e;
          r = exp_req_q.pop_front();
          e = exp_ok_q.pop_front();
          chk(r, "ok", ok, e);
        end
      end
      if (wr_valid) begin
        chk("R8", "cmd_ready while write pending", cmd_ready, 0);
        if (exp_wr_q.size() == 0) chk("R9", "unexpected write", 1, 0);
        else chk("R8", "write addr/data", {wr_addr, wr_data}, exp_wr_q[0]);
        if (stall_left > 0) begin
          stall_left--;
          wr_ready = 1'b0;
        end else begin
          wr_ready = 1'b1;
          if (exp_wr_q.size() != 0) void'(exp_wr_q.pop_front());
        end
      end else wr_ready = 1'b0;
    end
  end

  task automatic check_state(input string req);
    @(negedge clk);
    chk("R11", "done width", done, 0);
    chk(req, "wr_valid idle", wr_valid, 0);
    chk(req, "cbc_o", cbc_o, m_cbc);
    chk(req, "encrypt_o", encrypt_o, m_enc);
    for (int k = 0; k < 2; k++) begin
      key_rd_ctx = 1'(k);
      #1;
      chk(req, $sformatf("key%0d bytes", k), key_o, m_key[k]);
      chk(req, $sformatf("key%0d len", k), key_len_o, m_len[k]);
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      iv_rd_ctx = 2'(i);
      #1;
      chk(req, $sformatf("iv%0d", i), iv_o, m_iv[i]);
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [31:0] w, input int cnt,
                      input logic [255:0] pw, input string req, input int stall);
    bit okx = 0;
    case (op)
      2'd0: if (w[17] == 1'b0) begin
        int lb;
        m_cbc = w[16];
        m_enc = w[20];
        if (w[26:24] != 0) begin
          m_key[w[27]] = 256'(w[26:24]);
          m_len[w[27]] = 32;
          okx = 1;
        end else begin
          lb = (w[23:22] == 3) ? 64 : 16 + 8 * int'(w[23:22]);
          if (lb <= 32 && cnt >= lb / 4) begin
            for (int i = 0; i < lb / 4; i++) m_key[w[27]][32*i +: 32] = pw[32*i +: 32];
            m_len[w[27]] = lb;
            okx = 1;
          end
        end
      end
      2'd1: if (cnt >= 4) begin m_iv[w[27:26]] = pw[127:0]; okx = 1; end
      2'd2: if (cnt >= 1) begin
        exp_wr_q.push_back({w[7:0], pw[31:0], m_iv[w[27:26]]});
        okx = 1;
      end
      default: okx = 0;
    endcase
    exp_ok_q.push_back(okx);
    exp_req_q.push_back(req);
    stall_left = stall;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_word = w;
    pld_cnt = CNT_W'(cnt); pld_words = pw;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (exp_ok_q.size() != 0) @(negedge clk);
    check_state(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [255:0] p1, p2, p3, p4, p5;
    p1 = 256'h1f1e1d1c_1b1a1918_17161514_13121110_0f0e0d0c_0b0a0908_07060504_03020100;
    p2 = 256'hfeedface_cafef00d_0badc0de_d00dfeed_a1b2c3d4_e5f60718_293a4b5c_6d7e8f90;
    p3 = 256'h0_00000000_00000000_55555555_66666666_77777777_88888888_99999999_aaaaaaaa;
    p4 = 256'h44444444_33333333_22222222_11111111_deadbeef_01234567_89abcdef_76543210;
    p5 = 256'h0_00000000_00000000_00000000_f0f0f0f0_0f0f0f0f_c3c3c3c3_3c3c3c3c;
    for (int k = 0; k < 2; k++) begin m_key[k] = '0; m_len[k] = 0; end
    for (int i = 0; i < 4; i++) m_iv[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "cmd_ready", cmd_ready, 1);
    chk("R1", "done", done, 0);
    check_state("R1");

    send(2'd0, mk_key(1, 2, 0, 1, 1), 0, '0, "R3", 0);      // built-in, CBC encrypt
    send(2'd0, mk_key(0, 0, 0, 0, 0), 4, p1, "R4", 0);      // 16-byte host key
    send(2'd0, mk_key(0, 0, 2, 1, 0), 8, p2, "R4", 0);      // 32-byte host key
    send(2'd0, mk_key(0, 0, 1, 0, 1), 6, p3, "R4", 0);      // 24 bytes, tail kept
    send(2'd0, mk_key(1, 0, 3, 1, 1), 8, p1, "R5", 0);      // 64 bytes rejected
    send(2'd0, mk_key(1, 0, 2, 0, 0), 7, p1, "R6", 0);      // short payload
    send(2'd0, mk_key(1, 3, 0, 1, 2), 0, '0, "R2", 0);      // mode 2 rejected
    send(2'd0, mk_key(1, 0, 0, 1, 3), 4, p1, "R2", 0);      // mode 3 rejected
    send(2'd0, mk_key(0, 1, 2, 1, 1), 0, '0, "R3", 0);      // built-in over host key
    send(2'd1, mk_iv(3), 4, p4, "R7", 0);
    send(2'd1, mk_iv(1), 5, p5, "R7", 0);
    send(2'd1, mk_iv(2), 3, p4, "R7", 0);                   // short IV
    send(2'd2, mk_st(3, 8'ha5), 1, 256'h12345678, "R8", 3); // stalled write
    send(2'd2, mk_st(1, 8'h01), 2, 256'h0000ff00, "R8", 0);
    send(2'd2, mk_st(0, 8'h7e), 0, 256'h1, "R9", 0);
    send(2'd3, mk_iv(0), 8, p2, "R10", 0);
    chk("R8", "writes drained", exp_wr_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule